// File: doc/BRIEF.md
# Event-Driven Display Register Controller

This block keeps a 16-bit display value and drives it onto a 16-bit output port. Two asynchronous event lines act on that value. An event on the entry line takes the 4-bit input port and appends it to the value. The older contents move up by one nibble and the new nibble fills the low four bits. A 16-bit number is therefore keyed in over four events. An event on the compute line hands the current value to an external engine, which finds the smallest integer of 2 or more that shares no factor with it. The engine's answer replaces the value, and the block then shows it on the output port.

The block does no arithmetic itself. It synchronises the two event lines and keeps each event until it can be served. It orders events that arrive together and runs a start/done handshake with the engine. A compute event is dropped when the value is zero, so the engine is never started on a zero argument.

Top module: `dispEventCtrl`

## Requirements
- R1: While the synchronous reset `rst` is high, the display value, the output port and both pending-event flags are cleared, and `engStart` is low. An event whose edge arrived just before reset is not served afterwards.
- R2: A served entry event sets the value to `{value[11:0], nibbleIn}`. The output port shows the new value a few cycles later.
- R3: Four entry events in a row assemble a full 16-bit value, with the first nibble entered ending up in bits 15:12.
- R4: Each rising edge of an event line is served exactly once, however many cycles the line stays high.
- R5: A compute event served while the value is zero does nothing. No `engStart` is issued, and the value and the output port are unchanged.
- R6: A compute event served while the value is nonzero raises `engStart` for exactly one cycle, with `engArg` equal to the value.
- R7: When `engDone` is high, `engResult` is written into the value, and the output port then shows it.
- R8: An entry event arriving while the engine is busy is kept pending, not lost. It is applied to the engine's result once the result has been stored.
- R9: A compute event arriving while the engine is busy is ignored, so only one `engStart` is issued.
- R10: When both event lines rise in the same cycle, the entry event is served first, and the computation uses the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nibbleEvt | input | 1 | Asynchronous entry event line, acts on its rising edge |
| computeEvt | input | 1 | Asynchronous compute event line, acts on its rising edge |
| nibbleIn | input | 4 | Narrow input port, sampled when an entry event is served |
| engStart | output | 1 | One-cycle request to the relative-prime engine |
| engArg | output | 16 | Argument for the engine (the display value) |
| engDone | input | 1 | Engine reports that its result is valid |
| engResult | input | 16 | Engine result |
| dispOut | output | 16 | Output port showing the display value |

## Verification
The main sequence interleaves entry and compute events over varied nibbles. Building 0x1234 shows that the nibbles are ordered and shifted, not ORed in or reversed. The compute events use values whose answers are 2, 3 and 5, which separates the true engine result from a stale value or from the argument itself. The directed cases overlap the events. An entry event during a computation must land on the result. A second compute event during a computation must not restart the engine. Two events in the same cycle must give `{old, nibble}` as the engine argument, not the value before the nibble was added.

// File: rtl/dispPkg.sv
package dispPkg;
  parameter int DISP_W = 16;
  parameter int NIB_W  = 4;
  parameter int SYNC_STAGES = 2;
  localparam int NUM_SRC = 2;
  localparam int SRC_NIB = 0;
  localparam int SRC_CMP = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHOW_IN,
    ST_KICK,
    ST_WAIT,
    ST_SHOW_RES
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadResult;
    logic publish;
    logic hold;
  } dispStrobe_t;
endpackage

// File: rtl/dispEdgeSync.sv
module dispEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic risePulse
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN-2:0], rawIn};
  end

  assign risePulse = chain[CHAIN-2] & ~chain[CHAIN-1];

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    risePulse |=> !risePulse); // R4
endmodule

// File: rtl/dispControl.sv
module dispControl
  import dispPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        nibEdge,
  input  logic        cmpEdge,
  input  logic        regZero,
  input  logic        engDone,
  output logic        engStart,
  output dispStrobe_t strb
);
  ctrlState_t state, stateNext;
  logic nibPend, cmpPend;
  logic serveNib, serveCmp, engBusy;

  assign engBusy  = (state == ST_KICK) || (state == ST_WAIT);
  assign serveNib = (state == ST_IDLE) && nibPend;
  assign serveCmp = (state == ST_IDLE) && !nibPend && cmpPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      nibPend <= 1'b0;
      cmpPend <= 1'b0;
    end else begin
      nibPend <= (nibPend && !serveNib) || nibEdge;
      cmpPend <= (cmpPend && !serveCmp) || (cmpEdge && !engBusy);
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    engStart  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (serveNib) begin
          strb.shiftIn = 1'b1;
          stateNext    = ST_SHOW_IN;
        end else if (serveCmp && !regZero) begin
          stateNext = ST_KICK;
        end
      end
      ST_SHOW_IN: begin
        strb.publish = 1'b1;
        stateNext    = ST_IDLE;
      end
      ST_KICK: begin
        engStart  = 1'b1;
        strb.hold = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        strb.hold = 1'b1;
        if (engDone) begin
          strb.loadResult = 1'b1;
          stateNext       = ST_SHOW_RES;
        end
      end
      ST_SHOW_RES: begin
        strb.publish = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
    engStart |=> !engStart); // R6
  AST_NO_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    engStart |-> !regZero); // R5
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.shiftIn, strb.loadResult, engStart})); // R10
  AST_DONE_WAITS: assert property (@(posedge clk) disable iff (rst)
    engStart |=> !strb.loadResult); // R7
endmodule

// File: rtl/dispDatapath.sv
module dispDatapath
  import dispPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dispStrobe_t       strb,
  input  logic [NIB_W-1:0]  nibbleIn,
  input  logic [DISP_W-1:0] engResult,
  output logic [DISP_W-1:0] dispReg,
  output logic [DISP_W-1:0] dispOut,
  output logic              regZero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dispReg <= '0;
      dispOut <= '0;
    end else begin
      if (strb.shiftIn)
        dispReg <= {dispReg[DISP_W-NIB_W-1:0], nibbleIn};
      else if (strb.loadResult)
        dispReg <= engResult;
      if (strb.publish)
        dispOut <= dispReg;
    end
  end

  assign regZero = (dispReg == '0);

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strb.hold && $past(strb.hold)) |-> $stable(dispReg)); // R8
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.publish) |-> $stable(dispOut)); // R5
endmodule

// File: rtl/dispEventCtrl.sv
module dispEventCtrl
  import dispPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        nibbleEvt,
  input  logic        computeEvt,
  input  logic [3:0]  nibbleIn,
  output logic        engStart,
  output logic [15:0] engArg,
  input  logic        engDone,
  input  logic [15:0] engResult,
  output logic [15:0] dispOut
);
  logic [NUM_SRC-1:0] rawEvt, evtEdge;
  dispStrobe_t strb;
  logic [DISP_W-1:0] dispReg;
  logic regZero;

  assign rawEvt[SRC_NIB] = nibbleEvt;
  assign rawEvt[SRC_CMP] = computeEvt;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSync
    dispEdgeSync #(.STAGES(SYNC_STAGES)) uSync (
      .clk(clk), .rst(rst), .rawIn(rawEvt[i]), .risePulse(evtEdge[i]));
  end

  dispControl uCtrl (
    .clk(clk), .rst(rst),
    .nibEdge(evtEdge[SRC_NIB]), .cmpEdge(evtEdge[SRC_CMP]),
    .regZero(regZero), .engDone(engDone),
    .engStart(engStart), .strb(strb));

  dispDatapath uPath (
    .clk(clk), .rst(rst), .strb(strb),
    .nibbleIn(nibbleIn), .engResult(engResult),
    .dispReg(dispReg), .dispOut(dispOut), .regZero(regZero));

  assign engArg = dispReg;
endmodule

// File: tb/dispEventCtrl_test.sv
module dispEventCtrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nibbleEvt = 1'b0, computeEvt = 1'b0;
  logic [3:0] nibbleIn = '0;
  logic engStart, engDone = 1'b0;
  logic [15:0] engArg, engResult = '0, dispOut;
  int checks = 0, fails = 0, startCount = 0;
  logic [15:0] argSeen = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  dispEventCtrl uut (.clk(clk), .rst(rst), .nibbleEvt(nibbleEvt),
    .computeEvt(computeEvt), .nibbleIn(nibbleIn), .engStart(engStart),
    .engArg(engArg), .engDone(engDone), .engResult(engResult), .dispOut(dispOut));

  function automatic logic [15:0] gcdOf(logic [15:0] a, logic [15:0] b);
    logic [15:0] t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  function automatic logic [15:0] relPrime(logic [15:0] n);
    logic [15:0] m = 2;
    while (gcdOf(n, m) != 1) m++;
    return m;
  endfunction

  // engine model: answers five cycles after a start
  initial forever begin
    @(negedge clk);
    if (engStart) begin
      startCount++;
      argSeen = engArg;
      repeat (5) @(negedge clk);
      engResult = relPrime(argSeen);
      engDone = 1'b1;
      @(negedge clk);
      engDone = 1'b0;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fireNib(logic [3:0] v);
    @(negedge clk); nibbleIn = v; nibbleEvt = 1'b1;
    repeat (3) @(negedge clk); nibbleEvt = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic fireCmp();
    @(negedge clk); computeEvt = 1'b1;
    repeat (3) @(negedge clk); computeEvt = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // {isCompute, nibble, expected output}
  typedef struct packed { logic isCmp; logic [3:0] nib; logic [15:0] exp; } vec_t;
  localparam vec_t VECS [15] = '{
    '{1'b0, 4'h1, 16'h0001}, '{1'b0, 4'h2, 16'h0012},
    '{1'b0, 4'h3, 16'h0123}, '{1'b0, 4'h4, 16'h1234},
    '{1'b1, 4'h0, 16'h0003}, '{1'b0, 4'hF, 16'h003F},
    '{1'b1, 4'h0, 16'h0002}, '{1'b0, 4'h0, 16'h0020},
    '{1'b1, 4'h0, 16'h0003}, '{1'b0, 4'h9, 16'h0039},
    '{1'b1, 4'h0, 16'h0002}, '{1'b0, 4'h6, 16'h0026},
    '{1'b1, 4'h0, 16'h0003}, '{1'b0, 4'h0, 16'h0030},
    '{1'b1, 4'h0, 16'h0005}};

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    check("R1 reset out", dispOut, 16'h0000);
    check("R1 reset start", {15'b0, engStart}, 16'h0000);
    rst = 1'b0;
    // R5: compute on zero value
    s0 = startCount;
    fireCmp();
    check("R5 zero out", dispOut, 16'h0000);
    check("R5 zero no start", 16'(startCount - s0), 16'h0000);
    // R2 R3 R6 R7: main table
    for (int i = 0; i < 15; i++) begin
      if (VECS[i].isCmp) fireCmp(); else fireNib(VECS[i].nib);
      check(VECS[i].isCmp ? "R7 result" : "R2 R3 shift-in", dispOut, VECS[i].exp);
    end
    check("R6 engine argument", argSeen, 16'h0030);
    // R8: entry event during a computation
    s0 = startCount;
    @(negedge clk); computeEvt = 1'b1;
    @(negedge clk); @(negedge clk); nibbleIn = 4'h7; nibbleEvt = 1'b1;
    @(negedge clk); computeEvt = 1'b0;
    repeat (3) @(negedge clk); nibbleEvt = 1'b0;
    repeat (25) @(negedge clk);
    check("R8 held nibble", dispOut, 16'h0027);
    check("R8 one start", 16'(startCount - s0), 16'h0001);
    // R9: second compute edge while busy
    s0 = startCount;
    @(negedge clk); computeEvt = 1'b1;
    repeat (3) @(negedge clk); computeEvt = 1'b0;
    repeat (2) @(negedge clk); computeEvt = 1'b1;
    repeat (3) @(negedge clk); computeEvt = 1'b0;
    repeat (25) @(negedge clk);
    check("R9 ignored compute", 16'(startCount - s0), 16'h0001);
    check("R9 value", dispOut, 16'h0002);
    // R10: both lines together
    @(negedge clk); nibbleIn = 4'hB; nibbleEvt = 1'b1; computeEvt = 1'b1;
    repeat (3) @(negedge clk); nibbleEvt = 1'b0; computeEvt = 1'b0;
    repeat (25) @(negedge clk);
    check("R10 argument", argSeen, 16'h002B);
    check("R10 result", dispOut, relPrime(16'h002B));
    // R4: long-held entry line counts once
    @(negedge clk); nibbleIn = 4'h1; nibbleEvt = 1'b1;
    repeat (12) @(negedge clk); nibbleEvt = 1'b0;
    repeat (20) @(negedge clk);
    check("R4 single shift", dispOut, 16'h0021);
    // R1: reset clears value and a pending event
    @(negedge clk); nibbleIn = 4'h5; nibbleEvt = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b1;
    @(negedge clk); nibbleEvt = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 cleared value", dispOut, 16'h0000);
    check("R1 cleared argument", engArg, 16'h0000);
    summary();
  end
endmodule